// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block decodes the host write cycles aimed at a NOR-style flash array and turns the recognised command sequences into program operations on a small internal word array. In normal mode a program needs two unlock writes and a set-up write before the host supplies the target address and data. The host can instead enter a bypass mode. In bypass mode each program needs only the set-up write and the address/data write, until a two-write exit sequence returns the device to normal mode.

The time the cells take to program is modelled as a fixed number of clock cycles. During that time the ready output is low and every write is dropped. A read returns a polling word instead of array contents. Programming can only clear bits. The stored word becomes the old word ANDed with the new data. Asking for any 0 bit to become 1 is reported as a failure once the operation ends. An active-low hardware reset aborts everything at once and returns the array to its erased state.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and right after it is released, `ready` is 1 and `progFail` is 0, and every word of the array reads as all ones (erased).
- R2: The writes AAh at address 555h, then 55h at 2AAh, then A0h at 555h, then a target address with data start a program. `ready` is 0 for exactly PROG_CYCLES cycles, starting in the cycle after the address/data write.
- R3: When a program completes, the addressed word holds the old value ANDed with the written data.
- R4: An unlock or set-up write whose data or address differs from the values in R2 returns the sequencer to read mode. The next address/data write programs nothing.
- R5: Writes of any kind made while `ready` is 0 are ignored. After completion the sequencer is in read mode (or in bypass mode, if bypass was active).
- R6: Pulling `rstN` low during a program raises `ready` at once. The aborted word reads back erased.
- R7: While `ready` is 0, a read returns a polling word. Bit 7 is the complement of bit 7 of the data being programmed. Bit 6 is 0 on the first read and inverts after each read. Bit 5 is 1 if the program tries to set a 0 bit. Bits 4..0 are 0.
- R8: A program that tries to set a 0 bit completes with the cell left at the AND value, and `progFail` rises when `ready` returns. `progFail` clears when the next program starts.
- R9: The writes AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. There, A0h (any address) followed by an address/data write programs a word. This repeats with no unlock writes.
- R10: In bypass mode, a write whose data is neither A0h nor 90h is ignored and the device stays in bypass mode. A write of 90h followed by a non-00h write also leaves the device in bypass mode.
- R11: In bypass mode, 90h then 00h (addresses ignored) returns the device to read mode. An A0h/address/data pair then programs nothing.
- R12: While `ready` is 1, `rdData` shows the array word selected by the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| wrEn | input | 1 | Host write strobe, one write per cycle |
| rdEn | input | 1 | Host read strobe (advances the polling toggle) |
| addr | input | ADDR_W | Host address |
| wrData | input | DATA_W | Host write data / command byte |
| rdData | output | DATA_W | Array word, or polling word while busy |
| ready | output | 1 | 1 = idle, 0 = program in progress |
| progFail | output | 1 | Last program tried to set a cleared bit |

## Verification
The hardest states to reach are the two-step exits from bypass mode. A 90h write followed by a non-zero write must fall back into bypass, and a 90h/00h pair must leave it. Each outcome is visible only through whether a later program takes effect. The stimulus enters bypass, runs ignored and half-finished exit sequences, and then proves the mode through a program that does or does not change a word. A behavioural model in the bench tracks mode, busy time, toggle and array contents, and is compared with the outputs on every cycle. Commands injected during busy, the failing program and a reset fired mid-operation are also compared against that model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PADDR, ST_BUSY, ST_BYP, ST_BPADDR, ST_BRST
  } seqState_t;

  typedef struct packed {
    logic latch;   // capture target address/data, begin operation
    logic commit;  // write AND result into array, end operation
    logic busy;    // operation in progress
  } dpStrobe_t;

  localparam logic [7:0] CMD_UNL1   = 8'hAA;
  localparam logic [7:0] CMD_UNL2   = 8'h55;
  localparam logic [7:0] CMD_SETUP  = 8'hA0;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_EXIT1  = 8'h90;
  localparam logic [7:0] CMD_EXIT2  = 8'h00;
  localparam logic [11:0] ADR_A     = 12'h555;
  localparam logic [11:0] ADR_B     = 12'h2AA;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PROG_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  output dpStrobe_t         strobe
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADDR_1 = ADDR_W'(ADR_A);
  localparam logic [ADDR_W-1:0] ADDR_2 = ADDR_W'(ADR_B);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(PROG_CYCLES - 1);

  seqState_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic bypass;
  logic latch, commit;

  always_comb begin
    nxt = state;
    latch = 1'b0;
    commit = 1'b0;
    case (state)
      ST_READ:  if (wrEn) nxt = (cmd == CMD_UNL1 && addr == ADDR_1) ? ST_UNL1 : ST_READ;
      ST_UNL1:  if (wrEn) nxt = (cmd == CMD_UNL2 && addr == ADDR_2) ? ST_UNL2 : ST_READ;
      ST_UNL2:
        if (wrEn) begin
          if (cmd == CMD_SETUP && addr == ADDR_1)       nxt = ST_PADDR;
          else if (cmd == CMD_BYPASS && addr == ADDR_1) nxt = ST_BYP;
          else                                          nxt = ST_READ;
        end
      ST_PADDR, ST_BPADDR:
        if (wrEn) begin
          latch = 1'b1;
          nxt = ST_BUSY;
        end
      ST_BUSY:
        if (cnt == LAST) begin
          commit = 1'b1;
          nxt = bypass ? ST_BYP : ST_READ;
        end
      ST_BYP:
        if (wrEn) begin
          if (cmd == CMD_SETUP)      nxt = ST_BPADDR;
          else if (cmd == CMD_EXIT1) nxt = ST_BRST;
        end
      ST_BRST:  if (wrEn) nxt = (cmd == CMD_EXIT2) ? ST_READ : ST_BYP;
      default:  nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_READ;
      cnt    <= '0;
      bypass <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= (state == ST_BUSY && !commit) ? cnt + 1'b1 : '0;
      if (nxt == ST_BYP)       bypass <= 1'b1;
      else if (nxt == ST_READ) bypass <= 1'b0;
    end
  end

  assign strobe.latch  = latch;
  assign strobe.commit = commit;
  assign strobe.busy   = (state == ST_BUSY);
endmodule

// File: rtl/fcs_data.sv
module fcs_data
  import fcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              progFail
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  tgtIdx;
  logic [DATA_W-1:0] tgtData;
  logic viol, toggle, failReg;
  logic [DATA_W-1:0] pollWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      tgtIdx  <= '0;
      tgtData <= '0;
      viol    <= 1'b0;
      toggle  <= 1'b0;
      failReg <= 1'b0;
    end else begin
      if (strobe.latch) begin
        tgtIdx  <= idx;
        tgtData <= wrData;
        viol    <= |(wrData & ~mem[idx]);
        toggle  <= 1'b0;
        failReg <= 1'b0;
      end else if (strobe.busy && rdEn) begin
        toggle <= ~toggle;
      end
      if (strobe.commit) begin
        mem[tgtIdx] <= mem[tgtIdx] & tgtData;
        failReg     <= viol;
      end
    end
  end

  always_comb begin
    pollWord    = '0;
    pollWord[7] = ~tgtData[7];
    pollWord[6] = toggle;
    pollWord[5] = viol;
  end

  assign rdData   = strobe.busy ? pollWord : mem[idx];
  assign progFail = failReg;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int PROG_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic              progFail
);
  localparam int IDX_W = $clog2(DEPTH);

  dpStrobe_t ctrlBus;
  logic      wrGated;

  assign wrGated = wrEn & ~ctrlBus.busy;

  fcs_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrGated), .addr(addr),
    .cmd(wrData[7:0]), .strobe(ctrlBus)
  );

  fcs_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(ctrlBus), .rdEn(rdEn),
    .idx(addr[IDX_W-1:0]), .wrData(wrData), .rdData(rdData),
    .progFail(progFail)
  );

  assign ready = ~ctrlBus.busy;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import fcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              ready,
  input logic              progFail,
  input dpStrobe_t         strobe
);
  // R2: starting an operation drops ready on the next cycle
  a_r2_latch_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> !ready);

  // R5: no new operation can be captured while one is running
  a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !strobe.latch);

  // R7: unused polling bits are zero
  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (rdData[4:0] == 5'b0));

  // R7: each busy read inverts bit 6 for the next busy cycle
  a_r7_toggle_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && rdEn && !strobe.commit) |=> (rdData[6] != $past(rdData[6])));

  // R8: the failure flag rises only when an operation completes
  a_r8_fail_at_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progFail) |-> $past(strobe.commit));

  // R8: a new operation clears the failure flag
  a_r8_fail_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> !progFail);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdData(rdData),
  .ready(ready), .progFail(progFail), .strobe(ctrlBus)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int PROG = 6;
  localparam int NWORDS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic ready, progFail;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(12), .DATA_W(8), .DEPTH(NWORDS), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ready(ready), .progFail(progFail)
  );

  // behavioural reference model
  // modes: 0 read, 1 first unlock seen, 2 second unlock seen, 3 awaiting addr/data,
  //        4 bypass, 5 bypass awaiting addr/data, 6 bypass exit pending
  logic [7:0] mMem[$];
  int mMode, mLeft;
  bit mBusy, mByp, mTog, mViol, mFail;
  int mIdx;
  logic [7:0] mTd;

  task automatic modelReset();
    mMem = {};
    for (int i = 0; i < NWORDS; i++) mMem.push_back(8'hFF);
    mMode = 0; mLeft = 0; mBusy = 0; mByp = 0; mTog = 0;
    mViol = 0; mFail = 0; mIdx = 0; mTd = 8'h00;
  endtask

  function automatic logic [7:0] expRead(logic [11:0] a);
    if (mBusy) return {~mTd[7], mTog, mViol, 5'b0};
    return mMem[a % NWORDS];
  endfunction

  task automatic startProg(logic [11:0] a, logic [7:0] d);
    mIdx = a % NWORDS;
    mTd = d;
    mViol = ((d & ~mMem[mIdx]) != 0);
    mTog = 0; mFail = 0; mBusy = 1; mLeft = PROG;
  endtask

  task automatic modelStep(bit we, bit re, logic [11:0] a, logic [7:0] d);
    if (mBusy) begin
      if (re) mTog = ~mTog;
      mLeft--;
      if (mLeft == 0) begin
        mMem[mIdx] = mMem[mIdx] & mTd;
        mFail = mViol; mBusy = 0;
        mMode = mByp ? 4 : 0;
      end
    end else if (we) begin
      case (mMode)
        0: mMode = (d == 8'hAA && a == 12'h555) ? 1 : 0;
        1: mMode = (d == 8'h55 && a == 12'h2AA) ? 2 : 0;
        2: if (d == 8'hA0 && a == 12'h555) mMode = 3;
           else if (d == 8'h20 && a == 12'h555) begin mMode = 4; mByp = 1; end
           else mMode = 0;
        3, 5: startProg(a, d);
        4: if (d == 8'hA0) mMode = 5; else if (d == 8'h90) mMode = 6;
        6: if (d == 8'h00) begin mMode = 0; mByp = 0; end else mMode = 4;
        default: mMode = 0;
      endcase
    end
  endtask

  task automatic compare(string tag);
    logic [7:0] e;
    e = expRead(addr);
    checks++;
    if (ready !== !mBusy || progFail !== mFail || rdData !== e) begin
      fails++;
      $display("FAIL %s: ready=%0b progFail=%0b rdData=%02h expected ready=%0b progFail=%0b rdData=%02h",
               tag, ready, progFail, rdData, !mBusy, mFail, e);
    end
  endtask

  // one bus cycle: drive at negedge, compare, advance model with the edge
  task automatic cyc(string tag, bit we, bit re, logic [11:0] a, logic [7:0] d);
    wrEn = we; rdEn = re; addr = a; wrData = d;
    #1;
    compare(tag);
    @(posedge clk);
    modelStep(we, re, a, d);
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [11:0] a, logic [7:0] d);
    cyc(tag, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(string tag, logic [11:0] a);
    cyc(tag, 1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic pollUntilReady(string tag, logic [11:0] a);
    for (int i = 0; i < PROG + 2; i++) rd(tag, a);
  endtask

  task automatic unlock(string tag);
    wr(tag, 12'h555, 8'hAA);
    wr(tag, 12'h2AA, 8'h55);
  endtask

  task automatic expectWord(string tag, logic [11:0] a, logic [7:0] v);
    rd(tag, a);
    checks++;
    if (mMem[a % NWORDS] !== v) begin
      fails++;
      $display("FAIL %s: model word %02h expected %02h", tag, mMem[a % NWORDS], v);
    end
  endtask

  initial begin : watchdog
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    #1 compare("R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    // R1: erased after reset
    for (int i = 0; i < 4; i++) rd("R1 erased", 12'(i * 5));

    // R2, R7, R12: standard four-write program
    unlock("R2 unlock");
    wr("R2 setup", 12'h555, 8'hA0);
    wr("R2 addr/data", 12'h003, 8'h5A);
    pollUntilReady("R7 polling", 12'h003);
    expectWord("R12 readback", 12'h003, 8'h5A);

    // R8, R5: program that tries to set cleared bits, with writes while busy
    unlock("R8 unlock");
    wr("R8 setup", 12'h555, 8'hA0);
    wr("R8 addr/data", 12'h003, 8'h0F);
    wr("R5 busy write", 12'h555, 8'hAA);
    wr("R5 busy write", 12'h2AA, 8'h55);
    wr("R5 busy write", 12'h555, 8'hA0);
    pollUntilReady("R8 polling", 12'h003);
    expectWord("R3 AND result", 12'h003, 8'h0A);
    wr("R5 read mode after busy", 12'h004, 8'h00);
    expectWord("R5 no program after busy", 12'h004, 8'hFF);

    // R3, R8: bit-clearing only program clears the failure flag
    unlock("R3 unlock");
    wr("R3 setup", 12'h555, 8'hA0);
    wr("R3 addr/data", 12'h003, 8'h08);
    pollUntilReady("R8 clear", 12'h003);
    expectWord("R3 AND result", 12'h003, 8'h08);

    // R4: wrong unlock address, then wrong setup data
    wr("R4 unlock1", 12'h555, 8'hAA);
    wr("R4 bad unlock2", 12'h123, 8'h55);
    wr("R4 setup", 12'h555, 8'hA0);
    wr("R4 addr/data", 12'h005, 8'h00);
    rd("R4 still ready", 12'h005);
    unlock("R4 unlock");
    wr("R4 bad setup", 12'h555, 8'hA1);
    wr("R4 addr/data", 12'h005, 8'h00);
    expectWord("R4 untouched", 12'h005, 8'hFF);

    // R9: bypass entry and repeated two-write programs
    unlock("R9 unlock");
    wr("R9 enter bypass", 12'h555, 8'h20);
    wr("R9 setup", 12'h0F0, 8'hA0);
    wr("R9 addr/data", 12'h007, 8'h3C);
    pollUntilReady("R9 polling", 12'h007);
    wr("R9 setup", 12'h000, 8'hA0);
    wr("R9 addr/data", 12'h008, 8'hC3);
    pollUntilReady("R9 polling", 12'h008);
    expectWord("R9 word7", 12'h007, 8'h3C);
    expectWord("R9 word8", 12'h008, 8'hC3);

    // R10: stray writes and an incomplete exit keep bypass active
    wr("R10 stray", 12'h2AA, 8'h55);
    wr("R10 stray", 12'h009, 8'h00);
    expectWord("R10 ignored", 12'h009, 8'hFF);
    wr("R10 exit1", 12'h123, 8'h90);
    wr("R10 bad exit2", 12'h456, 8'h11);
    wr("R10 setup", 12'h555, 8'hA0);
    wr("R10 addr/data", 12'h00A, 8'h11);
    pollUntilReady("R10 polling", 12'h00A);
    expectWord("R10 still bypass", 12'h00A, 8'h11);

    // R11: proper exit returns to read mode
    wr("R11 exit1", 12'h321, 8'h90);
    wr("R11 exit2", 12'h654, 8'h00);
    wr("R11 setup", 12'h555, 8'hA0);
    wr("R11 addr/data", 12'h00B, 8'h00);
    expectWord("R11 no program", 12'h00B, 8'hFF);

    // R6: hardware reset during a program
    unlock("R6 unlock");
    wr("R6 setup", 12'h555, 8'hA0);
    wr("R6 addr/data", 12'h002, 8'h00);
    rd("R6 busy", 12'h002);
    rd("R6 busy", 12'h002);
    rstN = 1'b0;
    modelReset();
    #1 compare("R6 abort");
    @(negedge clk);
    rstN = 1'b1;
    expectWord("R6 word erased", 12'h002, 8'hFF);
    rd("R6 ready", 12'h003);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule